// File: doc/BRIEF.md
# Line-Aliasing Outstanding Request Table

This block sits between a processor-side memory port and the cache controller. It tracks every request in flight in two small associative tables. Read-class requests go into one table and write-class requests into the other. Each entry is keyed by the cache-line number, which is the request address without its offset-within-line bits. Each new request receives a status in the same cycle it is presented. The status is one of three: issued, aliased (the line already has a request in flight in either table) or busy (no room).

An admitted request produces a one-cycle issue strobe on the following cycle, carrying the line address and request kind toward the controller. When the controller completes a line, it presents the line and the table it belongs to. The block then retires the entry and, one cycle later, reports the stored kind and the number of cycles the request was outstanding. An unmatched completion is flagged as an error. Four counters record the aliasing rejections by category: write behind read, write behind write, read behind write, and read behind read.

Top module: `line_alias_table`

## Requirements
- R1: When the outstanding count has reached MAX_OUT (default 12), a presented request gets status busy (2'b10), ahead of any aliasing check, and increments no stall counter.
- R2: The key is the address with its low LINE_OFS bits (default 6) ignored, so addresses that differ only in those bits name the same line.
- R3: Kind codes are 4 bits. Code 0 (load) and code 1 (instruction fetch) are read class. Every code from 2 to 15 is write class: 2 store, 3 and 4 the two halves of a read-modify-write, 5 and 6 locked read-modify-write read and write, 7 load-linked, 8 store-conditional, 9 flush, 10–15 reserved.
- R4: A write-class request whose line is in the read table gets status aliased (2'b01) and increments the write-behind-read counter.
- R5: A write-class request whose line is in the write table gets status aliased and increments the write-behind-write counter.
- R6: A read-class request gets status aliased when its line is in the write table (read-behind-write counter) or in the read table (read-behind-read counter).
- R7: An admitted request gets status issued (2'b00). It raises issue_o for exactly the next cycle, with its line address (offset zeroed) and kind, and raises the outstanding count by one.
- R8: A request that would otherwise be admitted, but whose class table already holds ENTRIES (default 8) lines, gets status busy and increments no stall counter.
- R9: A completion matching an entry of the named table removes it. One cycle later, cpl_done_o pulses with the stored kind and a latency equal to the cycles elapsed from the admitting cycle to the completing cycle. The outstanding count drops by one.
- R10: A completion with no matching entry in the named table pulses cpl_err_o one cycle later, leaves the count unchanged, and never pulses cpl_done_o.
- R11: A request and a completion in the same cycle are judged against the table contents before that cycle's removal. A line retired in cycle N is admissible from cycle N+1.
- R12: After reset, the tables are empty, the count and all stall counters are zero, and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request presented this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_kind_i | input | 4 | Request kind code |
| req_status_o | output | 2 | Admission status, valid while req_valid_i is high |
| cpl_valid_i | input | 1 | Completion presented this cycle |
| cpl_write_i | input | 1 | Completion targets the write table (1) or read table (0) |
| cpl_addr_i | input | ADDR_W | Completed line address |
| cpl_done_o | output | 1 | Completion retired an entry (one cycle after) |
| cpl_err_o | output | 1 | Completion matched no entry (one cycle after) |
| cpl_kind_o | output | 4 | Kind stored in the retired entry |
| cpl_latency_o | output | TS_W | Cycles the retired request was outstanding |
| issue_o | output | 1 | One-cycle issue strobe for an admitted request |
| issue_line_o | output | ADDR_W | Line address of the issued request |
| issue_kind_o | output | 4 | Kind of the issued request |
| outstanding_o | output | $clog2(MAX_OUT+1) | Requests currently in flight |
| stall_wr_rd_o | output | CNT_W | Write-behind-read rejections |
| stall_wr_wr_o | output | CNT_W | Write-behind-write rejections |
| stall_rd_wr_o | output | CNT_W | Read-behind-write rejections |
| stall_rd_rd_o | output | CNT_W | Read-behind-read rejections |

## Verification
Same-line pairs are sent with different in-line offsets and with every class combination. This separates the four aliasing categories and shows that the offset bits are ignored and that the kind-to-class mapping is correct, including load-linked and flush. Filling the write table while the total stays below the limit separates the per-table busy case from the global limit. A request that would alias once the global limit is reached shows which check wins. Completions are presented with and without a matching entry, and against the wrong table, to exercise the error path. A request and a completion on one line in the same cycle show that admission sees the pre-removal table.

// File: rtl/lat_pkg.sv
package lat_pkg;

   localparam int KIND_W = 4;

   typedef enum logic [1:0] {
      ADM_ISSUED  = 2'b00,
      ADM_ALIASED = 2'b01,
      ADM_BUSY    = 2'b10
   } adm_status_e;

   typedef enum logic [KIND_W-1:0] {
      K_LOAD    = 4'd0,
      K_IFETCH  = 4'd1,
      K_STORE   = 4'd2,
      K_RMW_RD  = 4'd3,
      K_RMW_WR  = 4'd4,
      K_LRMW_RD = 4'd5,
      K_LRMW_WR = 4'd6,
      K_LINKED  = 4'd7,
      K_CONDST  = 4'd8,
      K_FLUSH   = 4'd9
   } req_kind_e;

   // write class: everything except plain loads and instruction fetches
   function automatic logic is_write_class(input logic [KIND_W-1:0] kind);
      return kind >= 4'd2;
   endfunction

endpackage

// File: rtl/lat_prio_enc.sv
module lat_prio_enc #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("lat_prio_enc: N must be at least 1");
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |req_i;
endmodule

// File: rtl/lat_stall_ctr.sv
module lat_stall_ctr #(
   parameter int CNT_W = 16,
   parameter bit SAT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);
   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("lat_stall_ctr: CNT_W must be positive");
      end
      if (SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                          count_o <= '0;
            else if (inc_i && (count_o != '1))   count_o <= count_o + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)      count_o <= '0;
            else if (inc_i)  count_o <= count_o + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/lat_table.sv
module lat_table #(
   parameter int ENTRIES = 8,
   parameter int KEY_W   = 26,
   parameter int KIND_W  = 4,
   parameter int TS_W    = 16,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [KEY_W-1:0]  lk_key_i,
   output logic              lk_hit_o,
   output logic              full_o,
   input  logic              ins_en_i,
   input  logic [KIND_W-1:0] ins_kind_i,
   input  logic [TS_W-1:0]   ins_ts_i,
   input  logic              rm_en_i,
   input  logic [KEY_W-1:0]  rm_key_i,
   output logic              rm_hit_o,
   output logic [KIND_W-1:0] rm_kind_o,
   output logic [TS_W-1:0]   rm_ts_o,
   output logic [OCC_W-1:0]  occ_o
);
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("lat_table: ENTRIES must be at least 2");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_q;
   logic [KEY_W-1:0]   key_q  [ENTRIES];
   logic [KIND_W-1:0]  kind_q [ENTRIES];
   logic [TS_W-1:0]    ts_q   [ENTRIES];

   logic [ENTRIES-1:0] lk_match, rm_match;
   logic [IDX_W-1:0]   free_idx;
   logic               free_any;

   genvar e;
   generate
      for (e = 0; e < ENTRIES; e++) begin : g_ent
         assign lk_match[e] = valid_q[e] && (key_q[e] == lk_key_i);
         assign rm_match[e] = valid_q[e] && (key_q[e] == rm_key_i);
      end
   endgenerate

   lat_prio_enc #(.N(ENTRIES)) u_free (
      .req_i (~valid_q),
      .idx_o (free_idx),
      .any_o (free_any)
   );

   assign lk_hit_o = |lk_match;
   assign rm_hit_o = |rm_match;
   assign full_o   = !free_any;

   always_comb begin
      rm_kind_o = '0;
      rm_ts_o   = '0;
      occ_o     = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (rm_match[i]) begin
            rm_kind_o = kind_q[i];
            rm_ts_o   = ts_q[i];
         end
         occ_o = occ_o + OCC_W'(valid_q[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            key_q[i]  <= '0;
            kind_q[i] <= '0;
            ts_q[i]   <= '0;
         end
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (rm_en_i && rm_match[i]) valid_q[i] <= 1'b0;
            if (ins_en_i && free_any && (free_idx == IDX_W'(i))) begin
               valid_q[i] <= 1'b1;
               key_q[i]   <= lk_key_i;
               kind_q[i]  <= ins_kind_i;
               ts_q[i]    <= ins_ts_i;
            end
         end
      end
   end

   // R6/R5: one line never held twice in a table
   a_r5_single_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   // R8: never insert into a full table
   a_r8_no_insert_full: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en_i |-> free_any);
   // R9: a removal request hits at most one entry
   a_r9_single_remove: assert property (@(posedge clk) disable iff (!rst_n)
      rm_en_i |-> $onehot0(rm_match));
endmodule

// File: rtl/line_alias_table.sv
module line_alias_table
   import lat_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFS = 6,
   parameter int ENTRIES  = 8,
   parameter int MAX_OUT  = 12,
   parameter int TS_W     = 16,
   parameter int CNT_W    = 16,
   parameter bit STALL_SAT = 1'b1,
   localparam int KEY_W   = ADDR_W - LINE_OFS,
   localparam int OUT_W   = $clog2(MAX_OUT + 1),
   localparam int OCC_W   = $clog2(ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [3:0]        req_kind_i,
   output logic [1:0]        req_status_o,
   input  logic              cpl_valid_i,
   input  logic              cpl_write_i,
   input  logic [ADDR_W-1:0] cpl_addr_i,
   output logic              cpl_done_o,
   output logic              cpl_err_o,
   output logic [3:0]        cpl_kind_o,
   output logic [TS_W-1:0]   cpl_latency_o,
   output logic              issue_o,
   output logic [ADDR_W-1:0] issue_line_o,
   output logic [3:0]        issue_kind_o,
   output logic [OUT_W-1:0]  outstanding_o,
   output logic [CNT_W-1:0]  stall_wr_rd_o,
   output logic [CNT_W-1:0]  stall_wr_wr_o,
   output logic [CNT_W-1:0]  stall_rd_wr_o,
   output logic [CNT_W-1:0]  stall_rd_rd_o
);
   generate
      if (LINE_OFS < 0 || LINE_OFS >= ADDR_W) begin : g_bad_ofs
         $error("line_alias_table: LINE_OFS must lie inside the address");
      end
      if (MAX_OUT < 1 || MAX_OUT > 2 * ENTRIES) begin : g_bad_max
         $error("line_alias_table: MAX_OUT must be 1..2*ENTRIES");
      end
      if (TS_W < 2) begin : g_bad_ts
         $error("line_alias_table: TS_W too narrow");
      end
   endgenerate

   logic [KEY_W-1:0] req_key, cpl_key;
   assign req_key = req_addr_i[ADDR_W-1:LINE_OFS];
   assign cpl_key = cpl_addr_i[ADDR_W-1:LINE_OFS];

   logic [TS_W-1:0]  now_q;
   logic [OUT_W-1:0] cnt_q;

   logic             rd_hit, wr_hit, rd_full, wr_full;
   logic             rd_rm_hit, wr_rm_hit;
   logic [3:0]       rd_rm_kind, wr_rm_kind;
   logic [TS_W-1:0]  rd_rm_ts, wr_rm_ts;
   logic [OCC_W-1:0] rd_occ, wr_occ;

   logic             req_wr, at_max, accept;
   logic             inc_wr_rd, inc_wr_wr, inc_rd_wr, inc_rd_rd;
   adm_status_e      status;

   assign req_wr = is_write_class(req_kind_i);
   assign at_max = (32'(cnt_q) >= MAX_OUT);

   // admission decision: global limit, then cross-table, then own table, then room
   always_comb begin
      status    = ADM_ISSUED;
      accept    = 1'b0;
      inc_wr_rd = 1'b0;
      inc_wr_wr = 1'b0;
      inc_rd_wr = 1'b0;
      inc_rd_rd = 1'b0;
      if (at_max) begin
         status = ADM_BUSY;
      end else if (req_wr) begin
         if (rd_hit) begin
            status    = ADM_ALIASED;
            inc_wr_rd = req_valid_i;
         end else if (wr_hit) begin
            status    = ADM_ALIASED;
            inc_wr_wr = req_valid_i;
         end else if (wr_full) begin
            status = ADM_BUSY;
         end else begin
            accept = req_valid_i;
         end
      end else begin
         if (wr_hit) begin
            status    = ADM_ALIASED;
            inc_rd_wr = req_valid_i;
         end else if (rd_hit) begin
            status    = ADM_ALIASED;
            inc_rd_rd = req_valid_i;
         end else if (rd_full) begin
            status = ADM_BUSY;
         end else begin
            accept = req_valid_i;
         end
      end
   end

   assign req_status_o = status;

   lat_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .KIND_W(4), .TS_W(TS_W)) u_rd_tab (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_key_i   (req_key),
      .lk_hit_o   (rd_hit),
      .full_o     (rd_full),
      .ins_en_i   (accept && !req_wr),
      .ins_kind_i (req_kind_i),
      .ins_ts_i   (now_q),
      .rm_en_i    (cpl_valid_i && !cpl_write_i),
      .rm_key_i   (cpl_key),
      .rm_hit_o   (rd_rm_hit),
      .rm_kind_o  (rd_rm_kind),
      .rm_ts_o    (rd_rm_ts),
      .occ_o      (rd_occ)
   );

   lat_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .KIND_W(4), .TS_W(TS_W)) u_wr_tab (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_key_i   (req_key),
      .lk_hit_o   (wr_hit),
      .full_o     (wr_full),
      .ins_en_i   (accept && req_wr),
      .ins_kind_i (req_kind_i),
      .ins_ts_i   (now_q),
      .rm_en_i    (cpl_valid_i && cpl_write_i),
      .rm_key_i   (cpl_key),
      .rm_hit_o   (wr_rm_hit),
      .rm_kind_o  (wr_rm_kind),
      .rm_ts_o    (wr_rm_ts),
      .occ_o      (wr_occ)
   );

   logic            cpl_hit, rm_ok;
   logic [3:0]      sel_kind;
   logic [TS_W-1:0] sel_ts;
   assign cpl_hit  = cpl_write_i ? wr_rm_hit  : rd_rm_hit;
   assign sel_kind = cpl_write_i ? wr_rm_kind : rd_rm_kind;
   assign sel_ts   = cpl_write_i ? wr_rm_ts   : rd_rm_ts;
   assign rm_ok    = cpl_valid_i && cpl_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q         <= '0;
         cnt_q         <= '0;
         issue_o       <= 1'b0;
         issue_line_o  <= '0;
         issue_kind_o  <= '0;
         cpl_done_o    <= 1'b0;
         cpl_err_o     <= 1'b0;
         cpl_kind_o    <= '0;
         cpl_latency_o <= '0;
      end else begin
         now_q <= now_q + 1'b1;
         if (accept && !rm_ok)      cnt_q <= cnt_q + 1'b1;
         else if (!accept && rm_ok) cnt_q <= cnt_q - 1'b1;
         issue_o       <= accept;
         issue_line_o  <= {req_key, {LINE_OFS{1'b0}}};
         issue_kind_o  <= req_kind_i;
         cpl_done_o    <= rm_ok;
         cpl_err_o     <= cpl_valid_i && !cpl_hit;
         cpl_kind_o    <= sel_kind;
         cpl_latency_o <= now_q - sel_ts;
      end
   end

   assign outstanding_o = cnt_q;

   lat_stall_ctr #(.CNT_W(CNT_W), .SAT(STALL_SAT)) u_c_wr_rd (
      .clk(clk), .rst_n(rst_n), .inc_i(inc_wr_rd), .count_o(stall_wr_rd_o));
   lat_stall_ctr #(.CNT_W(CNT_W), .SAT(STALL_SAT)) u_c_wr_wr (
      .clk(clk), .rst_n(rst_n), .inc_i(inc_wr_wr), .count_o(stall_wr_wr_o));
   lat_stall_ctr #(.CNT_W(CNT_W), .SAT(STALL_SAT)) u_c_rd_wr (
      .clk(clk), .rst_n(rst_n), .inc_i(inc_rd_wr), .count_o(stall_rd_wr_o));
   lat_stall_ctr #(.CNT_W(CNT_W), .SAT(STALL_SAT)) u_c_rd_rd (
      .clk(clk), .rst_n(rst_n), .inc_i(inc_rd_rd), .count_o(stall_rd_rd_o));

   // R7: the in-flight count equals the table occupancy
   a_r7_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_q) == 32'(rd_occ) + 32'(wr_occ));
   // R1: at the limit the count cannot grow
   a_r1_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(cnt_q) >= MAX_OUT) |=> (cnt_q <= $past(cnt_q)));
   // R7: an issued status is followed by the issue strobe
   a_r7_issue_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_status_o == ADM_ISSUED) |=> issue_o);
   // R9: a retired entry lowers the count by one (net of a same-edge admission)
   a_r9_done_drops_count: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_done_o |-> (32'(cnt_q) + 32'd1 == 32'($past(cnt_q)) + 32'(issue_o)));
   // R10: done and error never together
   a_r10_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpl_done_o && cpl_err_o));
endmodule

// File: tb/tb_line_alias_table.sv
`timescale 1ns/1ps
module tb_line_alias_table;
   localparam int ADDR_W = 32;
   localparam int OUT_W  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr  = '0;
   logic [3:0]        req_kind  = '0;
   logic [1:0]        req_status;
   logic              cpl_valid = 1'b0;
   logic              cpl_write = 1'b0;
   logic [ADDR_W-1:0] cpl_addr  = '0;
   logic              cpl_done, cpl_err, issue;
   logic [3:0]        cpl_kind, issue_kind;
   logic [15:0]       cpl_latency;
   logic [ADDR_W-1:0] issue_line;
   logic [OUT_W-1:0]  outstanding;
   logic [15:0]       s_wr_rd, s_wr_wr, s_rd_wr, s_rd_rd;

   line_alias_table dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_addr_i(req_addr), .req_kind_i(req_kind),
      .req_status_o(req_status),
      .cpl_valid_i(cpl_valid), .cpl_write_i(cpl_write), .cpl_addr_i(cpl_addr),
      .cpl_done_o(cpl_done), .cpl_err_o(cpl_err), .cpl_kind_o(cpl_kind),
      .cpl_latency_o(cpl_latency),
      .issue_o(issue), .issue_line_o(issue_line), .issue_kind_o(issue_kind),
      .outstanding_o(outstanding),
      .stall_wr_rd_o(s_wr_rd), .stall_wr_wr_o(s_wr_wr),
      .stall_rd_wr_o(s_rd_wr), .stall_rd_rd_o(s_rd_rd)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference model: line number -> kind / admit cycle
   int rd_kind[int], rd_ts[int], wr_kind[int], wr_ts[int];
   int e_wr_rd = 0, e_wr_wr = 0, e_rd_wr = 0, e_rd_rd = 0;

   // scoreboard of expected completion reports
   int q_err[$], q_kind[$], q_lat[$];

   // pending effects of the current cycle
   bit pend_acc; int pend_line; int pend_kind; int pend_ts;
   bit pend_rm;  bit pend_rm_wr; int pend_rm_line;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // drive a request in the current cycle and check its status
   task automatic req_begin(input int kind, input int addr);
      int line, exp;
      bit wr;
      string tag;
      line = addr >> 6;
      wr = (kind >= 2);
      req_valid = 1'b1; req_addr = addr; req_kind = 4'(kind);
      pend_acc = 0;
      if (rd_kind.num() + wr_kind.num() >= 12) begin exp = 2; tag = "R1"; end
      else if (wr) begin
         if (rd_kind.exists(line))      begin exp = 1; tag = "R4"; e_wr_rd++; end
         else if (wr_kind.exists(line)) begin exp = 1; tag = "R5"; e_wr_wr++; end
         else if (wr_kind.num() >= 8)   begin exp = 2; tag = "R8"; end
         else begin exp = 0; tag = "R7"; end
      end else begin
         if (wr_kind.exists(line))      begin exp = 1; tag = "R6"; e_rd_wr++; end
         else if (rd_kind.exists(line)) begin exp = 1; tag = "R6"; e_rd_rd++; end
         else if (rd_kind.num() >= 8)   begin exp = 2; tag = "R8"; end
         else begin exp = 0; tag = "R7"; end
      end
      if (exp == 0) begin
         pend_acc = 1; pend_line = line; pend_kind = kind; pend_ts = cyc;
      end
      #1;
      chk(req_status == 2'(exp), tag, "admission status", req_status, exp);
   endtask

   task automatic cpl_begin(input bit wr, input int addr);
      int line;
      line = addr >> 6;
      cpl_valid = 1'b1; cpl_write = wr; cpl_addr = addr;
      pend_rm = 0;
      if (wr && wr_kind.exists(line)) begin
         q_err.push_back(0); q_kind.push_back(wr_kind[line]);
         q_lat.push_back(cyc - wr_ts[line]);
         pend_rm = 1; pend_rm_wr = 1; pend_rm_line = line;
      end else if (!wr && rd_kind.exists(line)) begin
         q_err.push_back(0); q_kind.push_back(rd_kind[line]);
         q_lat.push_back(cyc - rd_ts[line]);
         pend_rm = 1; pend_rm_wr = 0; pend_rm_line = line;
      end else begin
         q_err.push_back(1); q_kind.push_back(0); q_lat.push_back(0);
      end
   endtask

   // clock edge, apply model updates, check issue strobe and count (R7)
   task automatic tick_end();
      @(posedge clk);
      #1;
      if (pend_rm) begin
         if (pend_rm_wr) begin wr_kind.delete(pend_rm_line); wr_ts.delete(pend_rm_line); end
         else begin rd_kind.delete(pend_rm_line); rd_ts.delete(pend_rm_line); end
      end
      if (req_valid) begin
         chk(issue == pend_acc, "R7", "issue strobe", issue, pend_acc);
         if (pend_acc) begin
            chk(issue_line == ADDR_W'(pend_line << 6), "R7", "issue line",
                issue_line, pend_line << 6);
            chk(issue_kind == 4'(pend_kind), "R7", "issue kind", issue_kind, pend_kind);
            if (pend_kind >= 2) begin wr_kind[pend_line] = pend_kind; wr_ts[pend_line] = pend_ts; end
            else begin rd_kind[pend_line] = pend_kind; rd_ts[pend_line] = pend_ts; end
         end
      end
      chk(int'(outstanding) == rd_kind.num() + wr_kind.num(), "R9", "outstanding",
          outstanding, rd_kind.num() + wr_kind.num());
      req_valid = 1'b0; cpl_valid = 1'b0;
      pend_acc = 0; pend_rm = 0;
   endtask

   task automatic do_req(input int kind, input int addr);
      @(negedge clk);
      req_begin(kind, addr);
      tick_end();
   endtask

   task automatic do_cpl(input bit wr, input int addr);
      @(negedge clk);
      cpl_begin(wr, addr);
      tick_end();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: completion reports one cycle after the completion (R9, R10)
   always @(negedge clk) begin
      if (rst_n && (cpl_done || cpl_err)) begin
         if (q_err.size() == 0) begin
            chk(0, "R10", "unexpected completion report", 1, 0);
         end else begin
            int ee, ek, el;
            ee = q_err.pop_front(); ek = q_kind.pop_front(); el = q_lat.pop_front();
            chk(cpl_err == ee[0], "R10", "error flag", cpl_err, ee);
            chk(cpl_done == !ee[0], "R9", "done flag", cpl_done, !ee[0]);
            if (!ee[0]) begin
               chk(cpl_kind == 4'(ek), "R9", "retired kind", cpl_kind, ek);
               chk(int'(cpl_latency) == el, "R9", "latency", cpl_latency, el);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12 reset state
      chk(outstanding == 0, "R12", "count after reset", outstanding, 0);
      chk(!issue && !cpl_done && !cpl_err, "R12", "strobes after reset",
          {issue, cpl_done, cpl_err}, 0);
      chk((s_wr_rd | s_wr_wr | s_rd_wr | s_rd_rd) == 0, "R12", "stall counters", 1, 0);

      do_req(2, 32'h1000);          // R7 store admitted
      do_req(0, 32'h1008);          // R6 load behind store, R2 offset ignored
      do_req(2, 32'h103F);          // R5 store behind store, R2
      do_req(0, 32'h2000);          // R7 load admitted
      do_req(1, 32'h2010);          // R6 ifetch behind load
      do_req(9, 32'h2004);          // R4 flush is write class (R3)
      do_req(7, 32'h3000);          // R3 load-linked is write class
      do_req(0, 32'h3020);          // R3 proves it: read behind write
      do_req(3, 32'h4000);          // R3 rmw half
      do_req(1, 32'h4040);          // R3 ifetch read class admitted
      idle(3);
      do_cpl(1, 32'h1000);          // R9 retire store
      do_cpl(0, 32'h5000);          // R10 no such line
      do_cpl(1, 32'h2000);          // R10 wrong table
      // R11 same-cycle request and completion on one line
      @(negedge clk);
      req_begin(8, 32'h3000);
      cpl_begin(1, 32'h3000);
      tick_end();
      do_req(8, 32'h3000);          // R11 admissible next cycle
      // R8 fill write table (holds 0x3000, 0x4000)
      for (int i = 0; i < 6; i++) do_req(2 + i, 32'h10000 + i * 64);
      do_req(2, 32'h20000);         // R8 write table full -> busy
      do_req(0, 32'h30000);         // read admitted, count 11
      do_req(0, 32'h30040);         // count 12
      do_req(0, 32'h30080);         // R1 at limit -> busy
      do_req(2, 32'h2000);          // R1 busy beats aliasing
      idle(2);
      // R4-R6 counters via ports; R1 and R8 added nothing
      chk(s_wr_rd == 16'(e_wr_rd), "R4", "write-behind-read count", s_wr_rd, e_wr_rd);
      chk(s_wr_wr == 16'(e_wr_wr), "R5", "write-behind-write count", s_wr_wr, e_wr_wr);
      chk(s_rd_wr == 16'(e_rd_wr), "R6", "read-behind-write count", s_rd_wr, e_rd_wr);
      chk(s_rd_rd == 16'(e_rd_rd), "R6", "read-behind-read count", s_rd_rd, e_rd_rd);
      // drain everything
      begin
         int wl[$], rl[$];
         foreach (wr_kind[k]) wl.push_back(k);
         foreach (rd_kind[k]) rl.push_back(k);
         foreach (wl[i]) do_cpl(1, wl[i] << 6);
         foreach (rl[i]) do_cpl(0, rl[i] << 6);
      end
      idle(3);
      chk(outstanding == 0, "R9", "drained count", outstanding, 0);
      chk(q_err.size() == 0, "R9", "unreported completions", q_err.size(), 0);
      report();
   end
endmodule